// File: doc/BRIEF.md
# Clock Stop and Restart Controller

This block sits between a clock synthesizer's two raw clocks and their output pads: a modulated main clock and an unmodulated reference clock. It decides when each pad toggles. An asynchronous, active-low power-down pin makes it stop both outputs cleanly in the low phase. Once both gates are confirmed shut, it asks the analog loop to power down. While stopped, the pads either float or are held low, as a mode bit selects. When the pin is released, the block holds both outputs stopped for a programmable settling interval, counted in reference-clock cycles, before it lets them run again.

Two enable bits stop either output on its own, outside power-down. A disabled output is driven low, its pad stays driven, and the loop keeps running. Every gate opens and closes only while its source clock is low. Every pulse that reaches a pad is therefore a full-width pulse.

The sequencer runs on the reference clock and has five states. RUN lets the gates follow their enables. DRAIN closes all gates and waits for every gate to report shut. OFF asserts the loop power-down request. SETTLE counts the settling interval. RELEASE drives the pads for one cycle before the gates reopen. The transitions are:

- RUN→DRAIN on a synchronized power-down request.
- DRAIN→OFF once a minimum drain time has elapsed and all gates report shut.
- OFF→SETTLE when the request clears.
- SETTLE→OFF if the request returns.
- SETTLE→RELEASE when the count completes.
- RELEASE→RUN on the next cycle, or RELEASE→OFF if the request has returned.
- Reset enters SETTLE.

Top module: `clkstop_ctrl`

## Requirements
- R1: Within 20 reference cycles of the power-down pin going low, both clock outputs rest at 0 with no further rising edges, and the loop power-down request is 1.
- R2: The loop power-down request is asserted only while every output gate is shut.
- R3: While stopped by power-down or settling, both output enables equal the mode bit (1 = drive low, 0 = float). During normal running both enables are 1, whatever the mode bit.
- R4: After the power-down pin returns high, the reference output shows no rising edge for at least SETTLE_CYCLES reference cycles, and does toggle again within SETTLE_CYCLES+8 cycles.
- R5: If the pin goes low again during settling, the count restarts, and the interval of R4 is measured from the final release.
- R6: The main enable (0 = stopped) and the reference enable (0 = stopped) each stop only their own output, held at 0. The output enables stay 1, and the loop request stays 0.
- R7: Every high pulse on either clock output lasts exactly half its source period, both when stopping and when starting.
- R8: The output enables are 1 for at least one reference cycle before the reference output resumes after power-down.
- R9: During reset both clock outputs are 0, the loop request is 0 and the output enables equal the mode bit. After reset the outputs start once the settling interval has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference source clock; clocks the sequencer |
| clk_main_i | input | 1 | Main (modulated) source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrdn_ni | input | 1 | Asynchronous active-low power-down pin |
| main_en_i | input | 1 | 1 = main output may run |
| ref_en_i | input | 1 | 1 = reference output may run |
| pd_drive_low_i | input | 1 | Stopped-pad mode: 1 = drive low, 0 = float |
| main_clk_o | output | 1 | Gated main clock |
| ref_clk_o | output | 1 | Gated reference clock |
| main_oe_o | output | 1 | Main pad output enable |
| ref_oe_o | output | 1 | Reference pad output enable |
| pll_pd_o | output | 1 | Loop/oscillator power-down request |

## Verification
Power-down cycles are driven with both stopped-pad modes, with and without a second low pulse in the middle of settling. A plain cycle measures the settling hold-off. A bounced cycle separates a counter that restarts from one that only pauses. Random enable pairs with a random mode bit show whether the enables act on their own outputs only and whether the mode bit leaks outside power-down. A pulse-width monitor watches every start and stop on both outputs for truncated pulses.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Output slots; index order is fixed by the top-level clock vector.
    localparam int OUT_MAIN = 0;
    localparam int OUT_REF  = 1;
    localparam int NUM_OUT  = 2;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_DRAIN,
        ST_OFF,
        ST_SETTLE,
        ST_RELEASE
    } seq_state_e;

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer with a selectable reset value.
module clkstop_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe <= {STAGES{RESET_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate: the run request is brought into the source
// clock domain and then registered on the falling edge, so the gate only
// moves while the source clock is low.
module clkstop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic want_i,
    output logic clk_o,
    output logic on_o
);
    logic want_s;
    logic on_q;

    clkstop_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b0)
    ) u_want_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (want_i),
        .q_o   (want_s)
    );

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            on_q <= 1'b0;
        end else begin
            on_q <= want_s;
        end
    end

    assign clk_o = clk_i & on_q;
    assign on_o  = on_q;
endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
// Power-down sequencer in the reference clock domain.
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int SETTLE_CYCLES = 144000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pd_req_i,
    input  logic all_shut_i,
    input  logic drive_low_i,
    output logic allow_o,
    output logic oe_o,
    output logic pll_pd_o,
    output logic running_o
);
    // Minimum time in DRAIN so that a run request still travelling through
    // a gate synchronizer has landed before the shut status is trusted.
    localparam int DRAIN_MIN = 2 * SYNC_STAGES + 3;
    localparam int CNT_MAX   = (SETTLE_CYCLES > DRAIN_MIN) ? SETTLE_CYCLES : DRAIN_MIN;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] DRAIN_LAST  = CNT_W'(DRAIN_MIN - 1);

    seq_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (pd_req_i) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (all_shut_i && (cnt_q >= DRAIN_LAST)) state_d = ST_OFF;
            end
            ST_OFF: begin
                if (!pd_req_i) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (pd_req_i)                  state_d = ST_OFF;
                else if (cnt_q == SETTLE_LAST) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (pd_req_i) state_d = ST_OFF;
                else          state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register and interval counter.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_SETTLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if ((state_d == state_q) &&
                ((state_q == ST_SETTLE) || (state_q == ST_DRAIN))) begin
                if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        allow_o   = 1'b0;
        oe_o      = drive_low_i;
        pll_pd_o  = 1'b0;
        running_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                allow_o   = 1'b1;
                oe_o      = 1'b1;
                running_o = 1'b1;
            end
            ST_DRAIN: begin
                oe_o = 1'b1;
            end
            ST_OFF: begin
                pll_pd_o = 1'b1;
            end
            ST_SETTLE: begin
                oe_o = drive_low_i;
            end
            ST_RELEASE: begin
                oe_o = 1'b1;
            end
            default: begin
                pll_pd_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int SETTLE_CYCLES = 144000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_ref_i,
    input  logic clk_main_i,
    input  logic rst_ni,
    input  logic pwrdn_ni,
    input  logic main_en_i,
    input  logic ref_en_i,
    input  logic pd_drive_low_i,
    output logic main_clk_o,
    output logic ref_clk_o,
    output logic main_oe_o,
    output logic ref_oe_o,
    output logic pll_pd_o
);
    logic               pwrdn_s;
    logic               pd_req;
    logic               allow;
    logic               running;
    logic               oe;
    logic               all_shut;
    logic [NUM_OUT-1:0] src_clk;
    logic [NUM_OUT-1:0] out_clk;
    logic [NUM_OUT-1:0] out_en;
    logic [NUM_OUT-1:0] gate_on;
    logic [NUM_OUT-1:0] gate_on_s;

    assign src_clk[OUT_MAIN] = clk_main_i;
    assign src_clk[OUT_REF]  = clk_ref_i;
    assign out_en[OUT_MAIN]  = main_en_i;
    assign out_en[OUT_REF]   = ref_en_i;

    // The pin idles high, so its synchronizer resets to 1.
    clkstop_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_pd_sync (
        .clk_i (clk_ref_i),
        .rst_ni(rst_ni),
        .d_i   (pwrdn_ni),
        .q_o   (pwrdn_s)
    );
    assign pd_req = ~pwrdn_s;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        clkstop_gate #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_gate (
            .clk_i (src_clk[i]),
            .rst_ni(rst_ni),
            .want_i(allow & out_en[i]),
            .clk_o (out_clk[i]),
            .on_o  (gate_on[i])
        );

        clkstop_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b0)
        ) u_on_sync (
            .clk_i (clk_ref_i),
            .rst_ni(rst_ni),
            .d_i   (gate_on[i]),
            .q_o   (gate_on_s[i])
        );
    end

    assign all_shut = ~|gate_on_s;

    clkstop_seq #(
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_seq (
        .clk_i      (clk_ref_i),
        .rst_ni     (rst_ni),
        .pd_req_i   (pd_req),
        .all_shut_i (all_shut),
        .drive_low_i(pd_drive_low_i),
        .allow_o    (allow),
        .oe_o       (oe),
        .pll_pd_o   (pll_pd_o),
        .running_o  (running)
    );

    assign main_clk_o = out_clk[OUT_MAIN];
    assign ref_clk_o  = out_clk[OUT_REF];
    assign main_oe_o  = oe;
    assign ref_oe_o   = oe;
endmodule

// File: rtl/clkstop_checker.sv
`timescale 1ns/1ps
module clkstop_checker #(
    parameter int SETTLE_CYCLES = 144000
) (
    input logic       clk_ref_i,
    input logic       clk_main_i,
    input logic       rst_ni,
    input logic       pd_req,
    input logic       allow,
    input logic       running,
    input logic [1:0] gate_on,
    input logic       main_oe_o,
    input logic       ref_oe_o,
    input logic       pll_pd_o
);
    // Reference cycles since the synchronized request last cleared.
    logic [31:0] quiet_cnt;
    always_ff @(posedge clk_ref_i or negedge rst_ni) begin
        if (!rst_ni)                   quiet_cnt <= '0;
        else if (pd_req)               quiet_cnt <= '0;
        else if (quiet_cnt != '1)      quiet_cnt <= quiet_cnt + 1;
    end

    assert_pll_pd_shut_R2: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        pll_pd_o |-> (gate_on == 2'b00));

    assert_oe_in_run_R3: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        running |-> (main_oe_o && ref_oe_o));

    assert_settle_hold_R4: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        $rose(allow) |-> (quiet_cnt >= 32'(SETTLE_CYCLES)));

    assert_oe_leads_R8: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
        $rose(allow) |-> $past(ref_oe_o));

    // Each gate may only move while its source clock is low.
    always @(gate_on[0]) begin
        if (rst_ni) begin
            assert_main_gate_low_R7: assert (!clk_main_i);
        end
    end
    always @(gate_on[1]) begin
        if (rst_ni) begin
            assert_ref_gate_low_R7: assert (!clk_ref_i);
        end
    end
endmodule

bind clkstop_ctrl clkstop_checker #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
) u_checker (
    .clk_ref_i (clk_ref_i),
    .clk_main_i(clk_main_i),
    .rst_ni    (rst_ni),
    .pd_req    (pd_req),
    .allow     (allow),
    .running   (running),
    .gate_on   (gate_on),
    .main_oe_o (main_oe_o),
    .ref_oe_o  (ref_oe_o),
    .pll_pd_o  (pll_pd_o)
);

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;
    localparam int CLK_PERIOD  = 20;
    localparam int MAIN_PERIOD = 14;
    localparam int SETTLE      = 40;

    logic clk_ref = 1'b0;
    logic clk_main = 1'b0;
    logic rst_n = 1'b0;
    logic pwrdn_n = 1'b1;
    logic main_en = 1'b1;
    logic ref_en = 1'b1;
    logic drive_low = 1'b1;
    logic main_clk_o, ref_clk_o, main_oe_o, ref_oe_o, pll_pd_o;

    int checks = 0;
    int errors = 0;
    int main_edges = 0;
    int ref_edges = 0;
    int runts = 0;
    bit done = 1'b0;
    time t_main_rise = 0;
    time t_ref_rise = 0;
    time t_oe_rise = 0;

    always #(CLK_PERIOD/2)  clk_ref  = ~clk_ref;
    always #(MAIN_PERIOD/2) clk_main = ~clk_main;

    clkstop_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
        .clk_ref_i     (clk_ref),
        .clk_main_i    (clk_main),
        .rst_ni        (rst_n),
        .pwrdn_ni      (pwrdn_n),
        .main_en_i     (main_en),
        .ref_en_i      (ref_en),
        .pd_drive_low_i(drive_low),
        .main_clk_o    (main_clk_o),
        .ref_clk_o     (ref_clk_o),
        .main_oe_o     (main_oe_o),
        .ref_oe_o      (ref_oe_o),
        .pll_pd_o      (pll_pd_o)
    );

    // Edge and pulse-width monitors (R7).
    always @(posedge main_clk_o) begin main_edges++; t_main_rise = $time; end
    always @(posedge ref_clk_o)  begin ref_edges++;  t_ref_rise  = $time; end
    always @(negedge main_clk_o) if (($time - t_main_rise) != MAIN_PERIOD/2) runts++;
    always @(negedge ref_clk_o)  if (($time - t_ref_rise)  != CLK_PERIOD/2)  runts++;
    always @(posedge ref_oe_o) t_oe_rise = $time;

    function automatic bit exp_oe_stopped(input bit mode);
        return mode;
    endfunction
    function automatic bit exp_toggles(input bit en, input bit pd);
        return en && !pd;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(posedge clk_ref);
        #(CLK_PERIOD/4);
    endtask

    task automatic pd_cycle(input bit mode, input bit bounce, input bit men);
        int n;
        int rb;
        int mb;
        main_en = men;
        drive_low = mode;
        wait_ref(1);
        pwrdn_n = 1'b0;
        wait_ref(20);
        check(main_clk_o == 1'b0, "R1 main low", main_clk_o, 0);
        check(ref_clk_o == 1'b0, "R1 ref low", ref_clk_o, 0);
        check(pll_pd_o == 1'b1, "R1 pll_pd", pll_pd_o, 1);
        rb = ref_edges;
        mb = main_edges;
        wait_ref(6);
        check((ref_edges - rb) + (main_edges - mb) == 0, "R1 no edges",
              (ref_edges - rb) + (main_edges - mb), 0);
        check(main_oe_o == exp_oe_stopped(mode) && ref_oe_o == exp_oe_stopped(mode),
              "R3 oe in power-down", main_oe_o, exp_oe_stopped(mode));
        if (bounce) begin
            pwrdn_n = 1'b1;
            wait_ref(SETTLE/2);
            check(ref_edges == rb, "R5 held mid-settle", ref_edges - rb, 0);
            pwrdn_n = 1'b0;
            wait_ref(5);
            check(pll_pd_o == 1'b1, "R5 back to off", pll_pd_o, 1);
        end
        pwrdn_n = 1'b1;
        rb = ref_edges;
        n = 0;
        while (ref_edges == rb && n < SETTLE + 60) begin
            wait_ref(1);
            n++;
            if (n == SETTLE/2)
                check(ref_oe_o == exp_oe_stopped(mode), "R3 oe in settle",
                      ref_oe_o, exp_oe_stopped(mode));
        end
        check(n >= SETTLE && n <= SETTLE + 8, bounce ? "R5 restart window" : "R4 restart window",
              n, SETTLE);
        check((t_ref_rise - t_oe_rise) >= CLK_PERIOD, "R8 oe lead",
              int'(t_ref_rise - t_oe_rise), CLK_PERIOD);
        mb = main_edges;
        wait_ref(6);
        check(((main_edges - mb) > 0) == exp_toggles(men, 1'b0), "R6 main after restart",
              main_edges - mb, exp_toggles(men, 1'b0));
    endtask

    initial begin
        int rb;
        int mb;
        void'($urandom(32'd4242));
        wait_ref(2);
        // R9: reset state
        check(main_clk_o == 1'b0 && ref_clk_o == 1'b0, "R9 clocks in reset", ref_clk_o, 0);
        check(pll_pd_o == 1'b0, "R9 pll_pd in reset", pll_pd_o, 0);
        check(main_oe_o == exp_oe_stopped(drive_low), "R9 oe in reset", main_oe_o, 1);
        rst_n = 1'b1;
        wait_ref(SETTLE - 4);
        check(ref_edges == 0, "R9 held after reset", ref_edges, 0);
        wait_ref(20);
        check(ref_edges > 0 && main_edges > 0, "R9 running after settle", ref_edges, 1);

        // Directed power-down cycles.
        pd_cycle(1'b1, 1'b0, 1'b1);
        pd_cycle(1'b0, 1'b0, 1'b1);
        pd_cycle(1'b0, 1'b1, 1'b1);
        pd_cycle(1'b1, 1'b1, 1'b0);

        // Random enable pairs with random mode bit (R6, R3).
        for (int k = 0; k < 12; k++) begin
            main_en = 1'($urandom);
            ref_en = 1'($urandom);
            drive_low = 1'($urandom);
            wait_ref(10);
            rb = ref_edges;
            mb = main_edges;
            wait_ref(10);
            check(((main_edges - mb) > 0) == exp_toggles(main_en, 1'b0), "R6 main enable",
                  main_edges - mb, exp_toggles(main_en, 1'b0));
            check(((ref_edges - rb) > 0) == exp_toggles(ref_en, 1'b0), "R6 ref enable",
                  ref_edges - rb, exp_toggles(ref_en, 1'b0));
            if (!main_en) check(main_clk_o == 1'b0, "R6 main held low", main_clk_o, 0);
            if (!ref_en)  check(ref_clk_o == 1'b0, "R6 ref held low", ref_clk_o, 0);
            check(main_oe_o && ref_oe_o, "R3 oe in run", main_oe_o, 1);
            check(pll_pd_o == 1'b0, "R6 pll stays on", pll_pd_o, 0);
        end

        // Random power-down cycles.
        ref_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            pd_cycle(1'($urandom), 1'($urandom), 1'($urandom));
        end

        check(runts == 0, "R7 full-width pulses", runts, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_ref);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule